// File: doc/BRIEF.md
# Bus Transaction Fault Watcher

This block sits beside a shared AHB-style bus. It looks for four kinds of fault. The first is a master that receives the bus and then leaves it idle for too long. The second is a slave that holds a data phase in wait states for too long. The third is a slave that answers with an ERROR response. The fourth is a burst that runs past an allowed number of beats. The block has no part in arbitration. It does not repair the faulted transfer. It only observes, records and reacts.

Each fault has its own limit input and its own 2-bit reaction field. The field selects status recording only, an interrupt, or a chip reset request. Every detected fault sets a sticky status bit. Software clears a status bit by writing a one to it. The interrupt line is the OR of the status bits whose interrupt enable is set and whose reaction is "interrupt". A reset request is a one-cycle pulse. The reset input must already be synchronised to `clk` on release.

Event indices used by the status, enable, mask and reaction fields: 0 = grant-idle, 1 = slave wait timeout, 2 = error response, 3 = over-long burst. Transfer type encoding: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11. `hresp` high means ERROR.

Top module: `bus_fault_watch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `status`, `irq` and `reset_req` are all 0.
- R2: A grant-idle fault (status bit 0) is detected when `grant_id` changes in a cycle whose transfer type is IDLE, and then IDLE cycles are counted from that cycle (that cycle counts as the first). The fault is detected on the cycle whose count reaches `idle_limit`+1. Any non-IDLE cycle clears the count. A further change of grant restarts it at 1. The fault is detected once per episode.
- R3: A data phase begins after a cycle with `hready`=1 and a NONSEQ or SEQ type. During a data phase, a cycle with `hready`=0 is a wait cycle. A slave timeout (status bit 1) is detected on the wait cycle numbered `wait_limit`+1 in an unbroken run of wait cycles. A cycle with `hready`=1 ends the run.
- R4: Each cycle with `hresp`=1 and `hready`=1 is an error fault (status bit 2).
- R5: A burst is counted in beats accepted with `hready`=1. NONSEQ sets the count to 1 and each SEQ adds 1. An over-long burst (status bit 3) is detected on the beat that makes the count `burst_limit`+1.
- R6: A detected fault shows in `status` from the next cycle and stays set. When `clr_we`=1, each bit set in `clr_mask` clears its status bit on the next cycle. A fault detected in the same cycle as its clear leaves the bit set.
- R7: `irq` is 1 exactly when some status bit i is set, `irq_en[i]`=1, and reaction field `act_cfg[2i+1:2i]` equals 01.
- R8: `reset_req` is 1 in the cycle after a fault whose reaction field is 10 or 11. It is never high for two cycles in a row: a second such fault in the pulse cycle is not turned into a pulse.
- R9: A fault whose reaction field is 00 sets its status bit but raises neither `irq` nor `reset_req`.
- R10: Idle cycles do not count toward a grant-idle fault until a change of `grant_id` has been seen since the last non-IDLE cycle or since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_id | input | GW | Index of the master currently granted |
| htrans | input | 2 | Transfer type of the current address phase |
| hready | input | 1 | Transfer done / slave ready |
| hresp | input | 1 | Slave response, 1 = ERROR |
| idle_limit | input | TW | Allowed IDLE cycles after a new grant |
| wait_limit | input | TW | Allowed wait cycles in one data phase |
| burst_limit | input | BW | Allowed beats in one burst |
| act_cfg | input | 8 | Reaction field per fault, 2 bits each, fault i at bits 2i+1:2i |
| irq_en | input | 4 | Interrupt enable per fault |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Status bits to clear when `clr_we` is high |
| status | output | 4 | Sticky fault status |
| irq | output | 1 | Interrupt request |
| reset_req | output | 1 | One-cycle chip reset request |

## Verification
Each fault is found from the inputs of the cycle in which it occurs. The fault's status bit, and therefore `irq`, change on the next rising edge. `reset_req` is registered and shows on that same next edge. `irq` also follows `irq_en` and `act_cfg` within the cycle, with no register in between. The bench drives inputs a quarter period after the rising edge. A behavioural model advances on each rising edge. All three outputs are compared with the model at the falling edge, half a period after the edge that should have moved them. Directed checks are read right after that edge, at the point the model says a result has just become due.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int NEV = 4;

  localparam int EV_GIDLE = 0;
  localparam int EV_SWAIT = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_BURST = 3;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    ACT_LOG  = 2'b00,
    ACT_IRQ  = 2'b01,
    ACT_RST  = 2'b10,
    ACT_RSTX = 2'b11
  } react_e;
endpackage

// File: rtl/bus_phase_track.sv
module bus_phase_track #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] grant_id,
  input  logic [1:0]    htrans,
  input  logic          hready,
  output logic          gi_tick,
  output logic          gi_clr,
  output logic          sw_tick,
  output logic          sw_clr,
  output logic          bl_tick,
  output logic          bl_clr
);
  import bfw_pkg::*;

  logic [GW-1:0] grant_q, grant_d;
  logic          armed_q, armed_d;
  logic          dph_q, dph_d;
  logic          idle, grant_chg, wait_cyc;

  always_comb begin
    idle      = (htrans == TR_IDLE);
    grant_chg = (grant_id != grant_q);
    wait_cyc  = dph_q & ~hready;

    gi_tick = idle & (armed_q | grant_chg);
    gi_clr  = grant_chg | ~idle;
    sw_tick = wait_cyc;
    sw_clr  = ~wait_cyc;
    bl_tick = hready & htrans[1];
    bl_clr  = hready & (htrans == TR_NONSEQ);

    grant_d = grant_id;
    if (!idle)          armed_d = 1'b0;
    else if (grant_chg) armed_d = 1'b1;
    else                armed_d = armed_q;
    dph_d = hready ? htrans[1] : dph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      armed_q <= 1'b0;
      dph_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      armed_q <= armed_d;
      dph_q   <= dph_d;
    end
  end
endmodule

// File: rtl/fault_counter.sv
module fault_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         fire
);
  localparam int CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_d, base, cnt_now, target;

  always_comb begin
    base    = clr ? '0 : cnt_q;
    cnt_now = (&base) ? base : base + CW'(1);
    target  = {1'b0, limit} + CW'(1);
    fire    = tick & (cnt_now == target);
    if (tick)     cnt_d = cnt_now;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fault_action.sv
module fault_action #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   ev,
  input  logic [2*N-1:0] act_cfg,
  input  logic [N-1:0]   irq_en,
  input  logic           clr_we,
  input  logic [N-1:0]   clr_mask,
  output logic [N-1:0]   status,
  output logic           irq,
  output logic           reset_req
);
  import bfw_pkg::*;

  logic [N-1:0] status_q, status_d, is_irq, is_rst;
  logic         rreq_q, rreq_d;

  for (genvar i = 0; i < N; i++) begin : g_ev
    logic [1:0] act_i;
    assign act_i       = act_cfg[2*i +: 2];
    assign is_irq[i]   = (act_i == ACT_IRQ);
    assign is_rst[i]   = act_i[1];
    assign status_d[i] = ev[i] | (status_q[i] & ~(clr_we & clr_mask[i]));
  end

  always_comb begin
    rreq_d = (|(ev & is_rst)) & ~rreq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      rreq_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      rreq_q   <= rreq_d;
    end
  end

  assign status    = status_q;
  assign irq       = |(status_q & irq_en & is_irq);
  assign reset_req = rreq_q;
endmodule

// File: rtl/bus_fault_watch.sv
module bus_fault_watch #(
  parameter int GW = 4,
  parameter int TW = 8,
  parameter int BW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GW-1:0]            grant_id,
  input  logic [1:0]               htrans,
  input  logic                     hready,
  input  logic                     hresp,
  input  logic [TW-1:0]            idle_limit,
  input  logic [TW-1:0]            wait_limit,
  input  logic [BW-1:0]            burst_limit,
  input  logic [2*bfw_pkg::NEV-1:0] act_cfg,
  input  logic [bfw_pkg::NEV-1:0]   irq_en,
  input  logic                     clr_we,
  input  logic [bfw_pkg::NEV-1:0]   clr_mask,
  output logic [bfw_pkg::NEV-1:0]   status,
  output logic                     irq,
  output logic                     reset_req
);
  import bfw_pkg::*;

  logic gi_tick, gi_clr, sw_tick, sw_clr, bl_tick, bl_clr;
  logic [NEV-1:0] ev;

  bus_phase_track #(.GW(GW)) u_track (
    .clk(clk), .rst_n(rst_n), .grant_id(grant_id), .htrans(htrans),
    .hready(hready), .gi_tick(gi_tick), .gi_clr(gi_clr),
    .sw_tick(sw_tick), .sw_clr(sw_clr), .bl_tick(bl_tick), .bl_clr(bl_clr)
  );

  fault_counter #(.W(TW)) u_gidle (
    .clk(clk), .rst_n(rst_n), .tick(gi_tick), .clr(gi_clr),
    .limit(idle_limit), .fire(ev[EV_GIDLE])
  );

  fault_counter #(.W(TW)) u_swait (
    .clk(clk), .rst_n(rst_n), .tick(sw_tick), .clr(sw_clr),
    .limit(wait_limit), .fire(ev[EV_SWAIT])
  );

  fault_counter #(.W(BW)) u_burst (
    .clk(clk), .rst_n(rst_n), .tick(bl_tick), .clr(bl_clr),
    .limit(burst_limit), .fire(ev[EV_BURST])
  );

  assign ev[EV_ERR] = hready & hresp;

  fault_action #(.N(NEV)) u_act (
    .clk(clk), .rst_n(rst_n), .ev(ev), .act_cfg(act_cfg), .irq_en(irq_en),
    .clr_we(clr_we), .clr_mask(clr_mask), .status(status), .irq(irq),
    .reset_req(reset_req)
  );
endmodule

// File: rtl/bus_fault_watch_chk.sv
module bus_fault_watch_chk #(
  parameter int BW = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                htrans,
  input logic                      hready,
  input logic                      hresp,
  input logic [BW-1:0]             burst_limit,
  input logic [2*bfw_pkg::NEV-1:0] act_cfg,
  input logic                      clr_we,
  input logic [bfw_pkg::NEV-1:0]   clr_mask,
  input logic [bfw_pkg::NEV-1:0]   status,
  input logic                      irq,
  input logic                      reset_req
);
  logic [bfw_pkg::NEV-1:0] keep;
  assign keep = status & ~(clr_we ? clr_mask : {bfw_pkg::NEV{1'b0}});

  // R4: an accepted ERROR response is recorded on the next cycle
  p_err_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && hresp) |=> status[2]);

  // R5: with a zero beat allowance the first beat already overruns
  p_burst_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == 2'b10 && burst_limit == '0) |=> status[3]);

  // R6: bits not being cleared stay set
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep)) == $past(keep)));

  // R7: no interrupt without a recorded fault
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

  // R8: the reset request never lasts two cycles
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R9: all reactions set to status only leave both outputs quiet
  p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg == '0) |-> !irq);
  p_quiet_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg == '0) |=> !reset_req);
endmodule

bind bus_fault_watch bus_fault_watch_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .htrans(htrans), .hready(hready), .hresp(hresp),
  .burst_limit(burst_limit), .act_cfg(act_cfg), .clr_we(clr_we),
  .clr_mask(clr_mask), .status(status), .irq(irq), .reset_req(reset_req)
);

// File: tb/test_bus_fault_watch.sv
module test_bus_fault_watch;
  localparam int GW = 4;
  localparam int TW = 8;
  localparam int BW = 5;

  logic          clk;
  logic          rst_n;
  logic [GW-1:0] grant_id;
  logic [1:0]    htrans;
  logic          hready, hresp;
  logic [TW-1:0] idle_limit, wait_limit;
  logic [BW-1:0] burst_limit;
  logic [7:0]    act_cfg;
  logic [3:0]    irq_en;
  logic          clr_we;
  logic [3:0]    clr_mask;
  logic [3:0]    status;
  logic          irq, reset_req;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  bus_fault_watch #(.GW(GW), .TW(TW), .BW(BW)) i_bus_fault_watch (
    .clk(clk), .rst_n(rst_n), .grant_id(grant_id), .htrans(htrans),
    .hready(hready), .hresp(hresp), .idle_limit(idle_limit),
    .wait_limit(wait_limit), .burst_limit(burst_limit), .act_cfg(act_cfg),
    .irq_en(irq_en), .clr_we(clr_we), .clr_mask(clr_mask), .status(status),
    .irq(irq), .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  logic [3:0]    m_status;
  logic          m_rr;
  logic [GW-1:0] m_gprev;
  bit            m_armed, m_dph;
  int            m_icnt, m_wcnt, m_bcnt;

  always @(posedge clk) begin
    logic [3:0] ev;
    bit rst_ev;
    cycles++;
    if (!rst_n) begin
      m_status = '0; m_rr = 0; m_gprev = '0; m_armed = 0; m_dph = 0;
      m_icnt = 0; m_wcnt = 0; m_bcnt = 0;
    end else begin
      ev = '0;
      if (htrans != 2'b00) begin
        m_armed = 0; m_icnt = 0;
      end else if (grant_id != m_gprev || m_armed) begin
        m_icnt  = (grant_id != m_gprev) ? 1 : m_icnt + 1;
        m_armed = 1;
        if (m_icnt == idle_limit + 1) ev[0] = 1;
      end
      m_gprev = grant_id;
      if (m_dph && !hready) begin
        m_wcnt++;
        if (m_wcnt == wait_limit + 1) ev[1] = 1;
      end else m_wcnt = 0;
      if (hready) m_dph = htrans[1];
      if (hready && htrans == 2'b10) m_bcnt = 1;
      else if (hready && htrans == 2'b11) m_bcnt++;
      if (hready && htrans[1] && m_bcnt == burst_limit + 1) ev[3] = 1;
      if (hready && hresp) ev[2] = 1;
      rst_ev = 0;
      for (int i = 0; i < 4; i++)
        if (ev[i] && act_cfg[2*i+1]) rst_ev = 1;
      m_status = (m_status & ~(clr_we ? clr_mask : 4'b0)) | ev;
      m_rr = rst_ev && !m_rr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq();
    bit r = 0;
    for (int i = 0; i < 4; i++)
      if (m_status[i] && irq_en[i] && act_cfg[2*i +: 2] == 2'b01) r = 1;
    return r;
  endfunction

  // every-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(status == 4'b0 && !irq && !reset_req, "R1 reset state",
          {status, irq, reset_req}, 0);
    end else begin
      for (int i = 0; i < 4; i++)
        chk(status[i] == m_status[i], $sformatf("R%0d status bit %0d", i + 2, i),
            status[i], m_status[i]);
      chk(irq == exp_irq(), "R7 irq", irq, exp_irq());
      chk(reset_req == m_rr, "R8 reset_req", reset_req, m_rr);
    end
  end

  task automatic drive(input logic [GW-1:0] g, input logic [1:0] t,
                       input logic rdy, input logic err, input int n);
    grant_id = g; htrans = t; hready = rdy; hresp = err;
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic w1c(input logic [3:0] m);
    htrans = 2'b00; hready = 1'b1; hresp = 1'b0;
    clr_we = 1'b1; clr_mask = m;
    @(posedge clk); #5;
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; grant_id = '0; htrans = 2'b00; hready = 1'b1; hresp = 1'b0;
    idle_limit = 8'd3; wait_limit = 8'd2; burst_limit = 5'd3;
    act_cfg = {2'b01, 2'b00, 2'b10, 2'b01};
    irq_en = 4'hF; clr_we = 1'b0; clr_mask = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    drive(0, 2'b00, 1, 0, 1);
    chk(status == 0 && !irq && !reset_req, "R1 first cycle after reset", status, 0);

    // R10: idle with no new grant never counts
    drive(0, 2'b00, 1, 0, 10);
    chk(status[0] == 0, "R10 idle without grant change", status[0], 0);

    // R2: new grant, limit 3 -> fires on 4th idle cycle
    drive(1, 2'b00, 1, 0, 3);
    chk(status[0] == 0, "R2 three idle cycles", status[0], 0);
    drive(1, 2'b00, 1, 0, 1);
    chk(status[0] == 1, "R2 fourth idle cycle", status[0], 1);
    chk(irq == 1, "R7 grant-idle interrupt", irq, 1);
    w1c(4'b0001);
    chk(status == 0, "R6 write-one clear", status, 0);

    // R2: non-idle before limit clears the count
    drive(2, 2'b00, 1, 0, 2);
    drive(2, 2'b10, 1, 0, 1);
    // R3: three wait cycles with limit 2
    drive(2, 2'b00, 0, 0, 2);
    chk(status[1] == 0, "R3 two wait cycles", status[1], 0);
    drive(2, 2'b00, 0, 0, 1);
    chk(status[1] == 1, "R3 third wait cycle", status[1], 1);
    chk(status[0] == 0, "R2 cleared by transfer", status[0], 0);
    chk(reset_req == 1, "R8 reset pulse", reset_req, 1);
    drive(2, 2'b00, 1, 0, 1);
    chk(reset_req == 0, "R8 pulse ends", reset_req, 0);

    // R4 and R9: error with status-only reaction
    w1c(4'hF);
    drive(2, 2'b00, 0, 1, 1);
    drive(2, 2'b00, 1, 1, 1);
    chk(status[2] == 1, "R4 error recorded", status[2], 1);
    chk(irq == 0, "R9 no irq for status-only", irq, 0);
    chk(reset_req == 0, "R9 no reset for status-only", reset_req, 0);

    // R5: 3 beats allowed, 4th overruns
    w1c(4'hF);
    drive(2, 2'b10, 1, 0, 1);
    drive(2, 2'b11, 1, 0, 2);
    chk(status[3] == 0, "R5 three beats", status[3], 0);
    drive(2, 2'b11, 1, 0, 1);
    chk(status[3] == 1, "R5 fourth beat", status[3], 1);
    chk(irq == 1, "R7 burst interrupt", irq, 1);
    irq_en = 4'b0111; #1;
    chk(irq == 0, "R7 interrupt masked", irq, 0);
    irq_en = 4'hF;

    // R6: fault and clear in the same cycle -> stays set
    w1c(4'hF);
    clr_we = 1'b1; clr_mask = 4'b0100;
    drive(2, 2'b00, 1, 1, 1);
    clr_we = 1'b0; clr_mask = '0;
    chk(status[2] == 1, "R6 set wins over clear", status[2], 1);

    // R8: back-to-back reset faults give one pulse
    act_cfg = 8'hAA;
    w1c(4'hF);
    drive(2, 2'b00, 1, 1, 1);
    chk(reset_req == 1, "R8 first fault pulses", reset_req, 1);
    drive(2, 2'b00, 1, 1, 1);
    chk(reset_req == 0, "R8 no second cycle", reset_req, 0);
    drive(2, 2'b00, 1, 0, 1);

    // mixed traffic, compared every cycle against the model
    idle_limit = 8'd1; wait_limit = 8'd1; burst_limit = 5'd2;
    act_cfg = {2'b01, 2'b11, 2'b00, 2'b01};
    r = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      grant_id = {2'b00, r[1:0] & {r[15], 1'b1}};
      htrans = r[3:2]; hready = r[4] | r[5]; hresp = r[6] & r[7] & r[8];
      clr_we = r[9] & r[10]; clr_mask = r[14:11];
      irq_en = {r[16] | r[17], 3'b111};
      @(posedge clk); #5;
    end
    clr_we = 1'b0;
    drive(0, 2'b00, 1, 0, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 5000) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, 5000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule